// File: doc/BRIEF.md
# Reloading Periodic Tick Timer

This block is a down-counting periodic timer that advances only on strobes from a fixed reference tick (nominally 38.4 MHz, delivered as a one-cycle enable pulse already synchronous to the block clock). Software programs a period and enable bits through a single 32-bit control word. Each time a full period of reference ticks elapses, a sticky event flag is set and the count restarts from the programmed period without software help.

A second, write-only acknowledge word lets software clear the flag and, if the timer is running, restart the current period from the programmed value. The block drives one interrupt request, which is raised while the flag and the interrupt enable are both set. Delivery of that request to a particular core is left to a separate router.

The register port is a plain synchronous write strobe with an address and data, and a combinational read of the addressed word. There is no streamed data and no back-pressure: every write is taken on the clock edge where the strobe is high.

Top module: `reload_tick_timer`

## Requirements
- R1: While reset is asserted, and right after it, the control word reads 0x00000000, the flag is clear and `irq_out` is low.
- R2: The control word reads back as bit 31 = event flag, bit 30 = restart-request bit, bit 29 = interrupt enable, bit 28 = run enable, bits [27:0] = period. Bits 30..0 read back as last written; a write of bit 31 through the control word has no effect on the flag.
- R3: After a control write with run enable = 1 and period N > 0, the flag stays clear through the first N-1 reference ticks and is set by the Nth.
- R4: After an expiry the count restarts by itself, so the flag is set again exactly N ticks after the previous expiry.
- R5: `irq_out` is high exactly when the flag and the interrupt enable are both set.
- R6: Writing the acknowledge word with bit 31 = 1 clears the flag; with bit 31 = 0 the flag is left unchanged.
- R7: Writing the acknowledge word with bit 30 = 1 while running restarts the period, so the next expiry comes N ticks after that write; while stopped it has no effect.
- R8: The acknowledge word and any unmapped address read as zero.
- R9: A control write with run enable = 0 stops the timer; no further expiry occurs however many ticks follow.
- R10: With run enable = 1 and period 0, the counter stays idle and the flag is never set.
- R11: When an expiry and an acknowledge clear land in the same cycle, the flag ends up set.
- R12: Clock cycles without a reference tick do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference tick strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the accessed word (control 0x04, acknowledge 0x08) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_out | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is an expiry and an acknowledge clear landing in the same clock edge. With a period of one, every reference tick is an expiry, so the bench raises the tick strobe and the acknowledge write in the same cycle and then reads the flag. The period sweep repeats over several idle gaps between ticks, which shows that only tick cycles advance the count. Restart and stop cases are reached by writing partway through a period.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int unsigned DEF_PERIOD_W = 28;
  localparam int unsigned DEF_AW       = 8;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CTRL = 2'd1,
    ACC_ACK  = 2'd2
  } acc_e;
endpackage

// File: rtl/rtt_regs.sv
module rtt_regs
  import rtt_pkg::*;
#(
  parameter int unsigned PERIOD_W  = DEF_PERIOD_W,
  parameter int unsigned AW        = DEF_AW,
  parameter logic [AW-1:0] CTRL_ADDR = 'h04,
  parameter logic [AW-1:0] ACK_ADDR  = 'h08,
  localparam int unsigned WORD_W = PERIOD_W + 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [AW-1:0]       reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  input  logic                expire,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                ld,
  output logic [PERIOD_W-1:0] ld_val,
  output logic                run_q,
  output logic                irq_en_q,
  output logic                flag_q,
  output logic [PERIOD_W-1:0] period_q
);
  localparam int unsigned RUN_POS  = PERIOD_W;
  localparam int unsigned IEN_POS  = PERIOD_W + 1;
  localparam int unsigned RST_POS  = PERIOD_W + 2;
  localparam int unsigned FLAG_POS = PERIOD_W + 3;

  acc_e acc;
  logic ctrl_wr, ack_wr;
  logic restart_q;

  always_comb begin
    if (reg_addr == CTRL_ADDR)     acc = ACC_CTRL;
    else if (reg_addr == ACK_ADDR) acc = ACC_ACK;
    else                           acc = ACC_NONE;
  end

  assign ctrl_wr = reg_wr && (acc == ACC_CTRL);
  assign ack_wr  = reg_wr && (acc == ACC_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      irq_en_q  <= 1'b0;
      restart_q <= 1'b0;
      period_q  <= '0;
    end else if (ctrl_wr) begin
      run_q     <= reg_wdata[RUN_POS];
      irq_en_q  <= reg_wdata[IEN_POS];
      restart_q <= reg_wdata[RST_POS];
      period_q  <= reg_wdata[PERIOD_W-1:0];
    end
  end

  // Expiry takes precedence over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              flag_q <= 1'b0;
    else if (expire)                         flag_q <= 1'b1;
    else if (ack_wr && reg_wdata[FLAG_POS])  flag_q <= 1'b0;
  end

  assign ld     = ctrl_wr || (ack_wr && reg_wdata[RST_POS] && run_q);
  assign ld_val = ctrl_wr ? (reg_wdata[RUN_POS] ? reg_wdata[PERIOD_W-1:0] : '0)
                          : period_q;

  always_comb begin
    unique case (acc)
      ACC_CTRL: reg_rdata = {flag_q, restart_q, irq_en_q, run_q, period_q};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter
  import rtt_pkg::*;
#(
  parameter int unsigned PERIOD_W = DEF_PERIOD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                ld,
  input  logic [PERIOD_W-1:0] ld_val,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                expire,
  output logic [PERIOD_W-1:0] cnt_q
);
  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  assign expire = !ld && run && tick && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (ld)                     cnt_q <= ld_val;
    else if (!run)                   cnt_q <= '0;
    else if (tick && cnt_q != '0)    cnt_q <= (cnt_q == ONE) ? period : cnt_q - ONE;
  end
endmodule

// File: rtl/reload_tick_timer.sv
module reload_tick_timer
  import rtt_pkg::*;
#(
  parameter int unsigned PERIOD_W  = DEF_PERIOD_W,
  parameter int unsigned AW        = DEF_AW,
  parameter logic [AW-1:0] CTRL_ADDR = 'h04,
  parameter logic [AW-1:0] ACK_ADDR  = 'h08,
  localparam int unsigned WORD_W = PERIOD_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_out
);
  logic                ld, expire, run_q, irq_en_q, flag_q;
  logic [PERIOD_W-1:0] ld_val, period_q, cnt_q;

  rtt_regs #(
    .PERIOD_W(PERIOD_W), .AW(AW), .CTRL_ADDR(CTRL_ADDR), .ACK_ADDR(ACK_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .expire(expire), .reg_rdata(reg_rdata),
    .ld(ld), .ld_val(ld_val), .run_q(run_q), .irq_en_q(irq_en_q),
    .flag_q(flag_q), .period_q(period_q)
  );

  rtt_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .ld(ld), .ld_val(ld_val),
    .run(run_q), .period(period_q), .expire(expire), .cnt_q(cnt_q)
  );

  assign irq_out = flag_q & irq_en_q;
endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
  parameter int unsigned PERIOD_W = 28,
  parameter int unsigned AW       = 8,
  parameter logic [AW-1:0] ACK_ADDR = 'h08,
  localparam int unsigned WORD_W = PERIOD_W + 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ref_tick,
  input logic                reg_wr,
  input logic [AW-1:0]       reg_addr,
  input logic [WORD_W-1:0]   reg_wdata,
  input logic                irq_out,
  input logic                flag,
  input logic                run,
  input logic                expire,
  input logic [PERIOD_W-1:0] cnt
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!flag && !irq_out));

  a_r3_flag_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(ref_tick));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ACK_ADDR && reg_wdata[WORD_W-1] && !ref_tick) |=> !flag);

  a_r11_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  a_r9_stopped_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !expire);

  a_r10_zero_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !reg_wr) |=> cnt == '0);

  a_r12_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_tick && !reg_wr) |=> $stable(cnt));
endmodule

bind reload_tick_timer rtt_checker #(
  .PERIOD_W(PERIOD_W), .AW(AW), .ACK_ADDR(ACK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_out(irq_out),
  .flag(flag_q), .run(run_q), .expire(expire), .cnt(cnt_q)
);

// File: tb/tb_reload_tick_timer.sv
module tb_reload_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CTRL = 8'h04;
  localparam logic [7:0] ACK  = 8'h08;
  localparam logic [31:0] B_FLAG = 32'h8000_0000;
  localparam logic [31:0] B_RST  = 32'h4000_0000;
  localparam logic [31:0] B_IEN  = 32'h2000_0000;
  localparam logic [31:0] B_RUN  = 32'h1000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_tick_timer dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic tick(input int gap);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic check_flag(input string req, input bit exp_flag, input bit ie);
    logic [31:0] v;
    rd(CTRL, v);
    check(req, {31'b0, v[31]}, {31'b0, exp_flag});
    check("R5", {31'b0, irq_out}, {31'b0, exp_flag & ie});
  endtask

  task automatic sweep(input int n, input int gap, input bit ie);
    wr(ACK, B_FLAG);
    wr(CTRL, B_RUN | (ie ? B_IEN : 32'h0) | 32'(n));
    for (int k = 1; k <= n; k++) begin
      tick(gap);
      check_flag("R3", k == n, ie);
    end
    wr(ACK, B_FLAG);
    check_flag("R6", 1'b0, ie);
    for (int k = 1; k <= n; k++) begin
      tick(gap);
      check_flag("R4", k == n, ie);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: state during reset
    rd(CTRL, v);
    check("R1", v, 32'h0);
    check("R1", {31'b0, irq_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(CTRL, v);
    check("R1", v, 32'h0);

    // R2: layout and read-only flag through the control word
    wr(CTRL, 32'hF000_0005);
    rd(CTRL, v);
    check("R2", v, 32'h7000_0005);
    // R8: acknowledge and unmapped words read zero
    rd(ACK, v);
    check("R8", v, 32'h0);
    rd(8'h0C, v);
    check("R8", v, 32'h0);

    // R3/R4/R5/R6/R12: sweep of periods, tick gaps and enables
    for (int n = 1; n <= 5; n++)
      for (int gap = 0; gap <= 2; gap++)
        sweep(n, gap, (n % 2) == 1);

    // R6: acknowledge without bit 31 keeps the flag
    wr(ACK, B_FLAG);
    wr(CTRL, B_RUN | B_IEN | 32'd2);
    tick(0); tick(0);
    wr(ACK, 32'h0);
    check_flag("R6", 1'b1, 1'b1);

    // R11: expiry and clear in the same cycle
    wr(ACK, B_FLAG);
    wr(CTRL, B_RUN | B_IEN | 32'd1);
    ref_tick = 1'b1;
    wr(ACK, B_FLAG);
    ref_tick = 1'b0;
    check_flag("R11", 1'b1, 1'b1);

    // R7: restart mid-period while running
    wr(ACK, B_FLAG);
    wr(CTRL, B_RUN | B_IEN | 32'd4);
    repeat (3) tick(0);
    wr(ACK, B_RST);
    repeat (3) tick(0);
    check_flag("R7", 1'b0, 1'b1);
    tick(0);
    check_flag("R7", 1'b1, 1'b1);

    // R12: idle cycles do not advance the count
    wr(ACK, B_FLAG);
    wr(CTRL, B_RUN | B_IEN | 32'd2);
    tick(20);
    check_flag("R12", 1'b0, 1'b1);
    tick(0);
    check_flag("R12", 1'b1, 1'b1);

    // R9 and R7: stopped timer never expires, restart request ignored
    wr(ACK, B_FLAG);
    wr(CTRL, B_RUN | B_IEN | 32'd4);
    tick(0);
    wr(CTRL, B_IEN | 32'd4);
    repeat (10) tick(0);
    check_flag("R9", 1'b0, 1'b1);
    wr(ACK, B_RST);
    repeat (10) tick(0);
    check_flag("R7", 1'b0, 1'b1);

    // R10: zero period stays idle
    wr(CTRL, B_RUN | B_IEN);
    repeat (10) tick(0);
    check_flag("R10", 1'b0, 1'b1);
    wr(ACK, B_RST);
    repeat (5) tick(0);
    check_flag("R10", 1'b0, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule